// File: doc/BRIEF.md
# Multi-Channel UART Sleep Controller

This block decides when a four-channel UART may stop its oscillator. Every clock it collects an idle verdict from each channel and combines them with a global sleep-enable bit. A channel is idle when it has no interrupt pending, both of its FIFOs are empty, its receive line rests at the idle level, its modem status inputs are all low and its baud divisor is nonzero. A transmit-holding write on any channel counts as activity. When the whole set has stayed idle for a programmable number of consecutive cycles, the controller enters sleep and lowers the clock-enable that gates the channels' clock.

The controller runs on the free-running reference clock, so it keeps watching while the channel logic is gated. Activity of any kind wakes the device on the next edge. Waking sets a latched wake-up interrupt flag, and a read of the global interrupt status register clears it. This flag does not depend on any interrupt mask. If sleep-enable is still set once every cause has gone away, the controller counts the idle window again and goes back to sleep without software help. The receive and modem lines are asynchronous, so they pass through a two-flop synchronizer before they are judged.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: During and right after reset, clk_en is 1, asleep is 0 and wake_irq is 0.
- R2: With sleep_en at 1, asleep goes to 1 on the 16th consecutive rising edge at which every channel is idle. A channel is idle when it has no pending interrupt, both FIFOs are empty, its synchronized RX line is at the idle level, its modem bits are zero, its divisor is nonzero, and no THR write is present. With sleep_en at 0, asleep never rises.
- R3: A pending interrupt, a non-empty transmit FIFO or a non-empty receive FIFO on any single channel keeps the block awake.
- R4: The RX idle level is 1 when that channel's ir_mode is 0 and 0 when ir_mode is 1. Any nonzero bit among a channel's four modem inputs blocks sleep. RX and modem inputs act two clock edges later than the other inputs because they pass through a synchronizer.
- R5: A divisor of zero on any channel (16 bits per channel, channel c at bits c*16 upward) keeps the block awake.
- R6: A break in the idle conditions lasting even one cycle restarts the 16-cycle count from zero.
- R7: While asleep, any of the following causes asleep to fall on the next edge: sleep_en cleared, a pending interrupt, a THR write, a change on a synchronized RX line, or a nonzero modem input. The last two take effect after the synchronizer delay.
- R8: The edge that ends sleep sets wake_irq, with no mask involved. wake_irq then holds until an edge at which status_rd is 1. If a wake and status_rd occur on the same edge, the flag is set.
- R9: After a wake, if sleep_en is still 1 and all causes clear, the block re-enters sleep after a fresh 16-cycle idle window.
- R10: clk_en is always the inverse of asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | 1 | Global permission to sleep |
| irq_pend | input | 4 | Per-channel interrupt pending |
| tx_fifo_empty | input | 4 | Per-channel transmit FIFO empty |
| rx_fifo_empty | input | 4 | Per-channel receive FIFO empty |
| rx_pin | input | 4 | Asynchronous per-channel receive line |
| ir_mode | input | 4 | Per-channel infrared mode (idle-low RX) |
| modem_in | input | 16 | Asynchronous modem status, 4 bits per channel |
| divisor | input | 64 | Baud divisor, 16 bits per channel |
| thr_wr | input | 4 | Per-channel transmit-holding write strobe |
| status_rd | input | 1 | Read of the global interrupt status register |
| clk_en | output | 1 | Gate enable for the channels' clock |
| asleep | output | 1 | Sleep status |
| wake_irq | output | 1 | Latched wake-up interrupt |

## Verification
The bench aims at the exact length of the idle window. A count that is off by one would have the block sleep one cycle early or late on the 15th or 16th edge. A one-cycle interruption must restart the count; a design that only pauses the counter would fall asleep too soon. The bench checks the two-edge synchronizer latency on RX and modem wakes, and the inverted RX idle level in infrared mode, which a design hard-wired to idle-high would get wrong. It also checks that a status read arriving on the same edge as a wake still leaves the flag set, and that the block re-enters sleep with no software action.

// File: rtl/uart_sleep_pkg.sv
package uart_sleep_pkg;
  typedef enum logic {
    PWR_RUN   = 1'b0,
    PWR_SLEEP = 1'b1
  } pwr_state_t;
endpackage

// File: rtl/uart_sleep_sync.sv
// Multi-stage synchronizer for asynchronous pins, per-bit reset value.
module uart_sleep_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/uart_sleep_chan_idle.sv
// Idle verdict of one channel from its already-synchronized inputs.
module uart_sleep_chan_idle #(
  parameter int MODEM_W = 4,
  parameter int DIV_W   = 16
) (
  input  logic               irq_pend,
  input  logic               tx_empty,
  input  logic               rx_empty,
  input  logic               rx_sync,
  input  logic               ir_mode,
  input  logic [MODEM_W-1:0] modem_sync,
  input  logic [DIV_W-1:0]   div,
  output logic               idle
);
  logic fifo_ok, line_ok, modem_ok, div_ok;

  always_comb begin
    fifo_ok  = tx_empty & rx_empty;
    line_ok  = (rx_sync != ir_mode);
    modem_ok = (modem_sync == '0);
    div_ok   = (div != '0);
    idle     = ~irq_pend & fifo_ok & line_ok & modem_ok & div_ok;
  end
endmodule

// File: rtl/uart_sleep_fsm.sv
// Idle-window counter, sleep state and latched wake flag.
module uart_sleep_fsm
  import uart_sleep_pkg::*;
#(
  parameter int ENTRY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic all_idle,
  input  logic status_rd,
  output logic clk_en,
  output logic asleep,
  output logic wake_irq
);
  localparam int CNT_W = (ENTRY_CYCLES > 2) ? $clog2(ENTRY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRY_CYCLES - 1);

  pwr_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             wake_evt;

  always_comb begin
    wake_evt = (state_q == PWR_SLEEP) & ~all_idle;
    state_d  = state_q;
    if (wake_evt)
      state_d = PWR_RUN;
    else if (state_q == PWR_RUN && all_idle && cnt_q == LAST)
      state_d = PWR_SLEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PWR_RUN;
      cnt_q    <= '0;
      asleep   <= 1'b0;
      clk_en   <= 1'b1;
      wake_irq <= 1'b0;
    end else begin
      state_q <= state_d;
      asleep  <= (state_d == PWR_SLEEP);
      clk_en  <= (state_d == PWR_RUN);
      if (!all_idle)
        cnt_q <= '0;
      else if (state_q == PWR_RUN && cnt_q != LAST)
        cnt_q <= cnt_q + 1'b1;
      if (wake_evt)
        wake_irq <= 1'b1;
      else if (status_rd)
        wake_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl #(
  parameter int NUM_CH       = 4,
  parameter int MODEM_W      = 4,
  parameter int DIV_W        = 16,
  parameter int ENTRY_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sleep_en,
  input  logic [NUM_CH-1:0]          irq_pend,
  input  logic [NUM_CH-1:0]          tx_fifo_empty,
  input  logic [NUM_CH-1:0]          rx_fifo_empty,
  input  logic [NUM_CH-1:0]          rx_pin,
  input  logic [NUM_CH-1:0]          ir_mode,
  input  logic [NUM_CH*MODEM_W-1:0]  modem_in,
  input  logic [NUM_CH*DIV_W-1:0]    divisor,
  input  logic [NUM_CH-1:0]          thr_wr,
  input  logic                       status_rd,
  output logic                       clk_en,
  output logic                       asleep,
  output logic                       wake_irq
);
  localparam int MODEM_BITS = NUM_CH * MODEM_W;

  logic [NUM_CH-1:0]     rx_s;
  logic [MODEM_BITS-1:0] modem_s;
  logic [NUM_CH-1:0]     ch_idle;
  logic                  all_idle;

  uart_sleep_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL({NUM_CH{1'b1}}))
    u_rx_sync (.clk(clk), .rst(rst), .d_async(rx_pin), .q_sync(rx_s));

  uart_sleep_sync #(.WIDTH(MODEM_BITS), .STAGES(SYNC_STAGES), .RST_VAL('0))
    u_modem_sync (.clk(clk), .rst(rst), .d_async(modem_in), .q_sync(modem_s));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    uart_sleep_chan_idle #(.MODEM_W(MODEM_W), .DIV_W(DIV_W)) u_idle (
      .irq_pend  (irq_pend[c]),
      .tx_empty  (tx_fifo_empty[c]),
      .rx_empty  (rx_fifo_empty[c]),
      .rx_sync   (rx_s[c]),
      .ir_mode   (ir_mode[c]),
      .modem_sync(modem_s[c*MODEM_W +: MODEM_W]),
      .div       (divisor[c*DIV_W +: DIV_W]),
      .idle      (ch_idle[c])
    );
  end

  assign all_idle = sleep_en & (&ch_idle) & ~(|thr_wr);

  uart_sleep_fsm #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .all_idle (all_idle),
    .status_rd(status_rd),
    .clk_en   (clk_en),
    .asleep   (asleep),
    .wake_irq (wake_irq)
  );
endmodule

// File: rtl/uart_sleep_ctrl_chk.sv
module uart_sleep_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sleep_en,
  input logic [NUM_CH-1:0]       irq_pend,
  input logic [NUM_CH-1:0]       thr_wr,
  input logic                    status_rd,
  input logic [NUM_CH*DIV_W-1:0] divisor,
  input logic                    clk_en,
  input logic                    asleep,
  input logic                    wake_irq
);
  logic div_zero;
  always_comb begin
    div_zero = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (divisor[c*DIV_W +: DIV_W] == '0) div_zero = 1'b1;
  end

  AST_CLKEN_INVERSE: assert property (@(posedge clk) disable iff (rst)
    clk_en == !asleep); // R10
  AST_ENTRY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> $past(sleep_en)); // R2
  AST_IRQ_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (|irq_pend) |=> !asleep); // R3
  AST_DIV_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    div_zero |=> !asleep); // R5
  AST_THR_WAKES: assert property (@(posedge clk) disable iff (rst)
    (asleep && (|thr_wr)) |=> (!asleep && wake_irq)); // R7
  AST_WAKE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep) |-> wake_irq); // R8
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wake_irq && !status_rd) |=> wake_irq); // R8
endmodule

bind uart_sleep_ctrl uart_sleep_ctrl_chk #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .sleep_en(sleep_en), .irq_pend(irq_pend),
  .thr_wr(thr_wr), .status_rd(status_rd), .divisor(divisor),
  .clk_en(clk_en), .asleep(asleep), .wake_irq(wake_irq)
);

// File: tb/tb_uart_sleep_ctrl.sv
module tb_uart_sleep_ctrl;
  localparam int NCH = 4, MW = 4, DW = 16, ENTRY = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst, sleep_en, status_rd;
  logic [NCH-1:0]    irq_pend, tx_fifo_empty, rx_fifo_empty, rx_pin, ir_mode, thr_wr;
  logic [NCH*MW-1:0] modem_in;
  logic [NCH*DW-1:0] divisor;
  logic              clk_en, asleep, wake_irq;

  uart_sleep_ctrl dut (
    .clk(clk), .rst(rst), .sleep_en(sleep_en), .irq_pend(irq_pend),
    .tx_fifo_empty(tx_fifo_empty), .rx_fifo_empty(rx_fifo_empty),
    .rx_pin(rx_pin), .ir_mode(ir_mode), .modem_in(modem_in),
    .divisor(divisor), .thr_wr(thr_wr), .status_rd(status_rd),
    .clk_en(clk_en), .asleep(asleep), .wake_irq(wake_irq)
  );

  int    n_checks = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  bit    cmp_on = 0;

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference: delayed pin history in queues, run length as an integer.
  logic [NCH-1:0]    rx_q[$];
  logic [NCH*MW-1:0] md_q[$];
  int m_run;
  bit m_asleep, m_irq;

  always @(posedge clk) begin
    logic [NCH-1:0]    rx_u;
    logic [NCH*MW-1:0] md_u;
    bit idle, was, woke;
    if (rst) begin
      rx_q.delete(); md_q.delete();
      rx_q.push_back('1); rx_q.push_back('1);
      md_q.push_back('0); md_q.push_back('0);
      m_run = 0; m_asleep = 0; m_irq = 0;
    end else begin
      rx_q.push_back(rx_pin); rx_u = rx_q.pop_front();
      md_q.push_back(modem_in); md_u = md_q.pop_front();
      idle = sleep_en && (thr_wr == '0);
      for (int ch = 0; ch < NCH; ch++)
        if (irq_pend[ch] || !tx_fifo_empty[ch] || !rx_fifo_empty[ch] ||
            rx_u[ch] == ir_mode[ch] || md_u[ch*MW +: MW] != '0 ||
            divisor[ch*DW +: DW] == '0)
          idle = 0;
      was  = m_asleep;
      woke = was && !idle;
      if (!idle) m_run = 0; else if (m_run < 1000) m_run++;
      if (woke) begin m_asleep = 0; m_irq = 1; end
      else if (!was && idle && m_run >= ENTRY) m_asleep = 1;
      if (!woke && status_rd) m_irq = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(cur_req, asleep, m_asleep, "asleep vs model");
      chk("R10", clk_en, !m_asleep, "clk_en vs model");
      chk(cur_req, wake_irq, m_irq, "wake_irq vs model");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<=20000 cycles", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic set_idle();
    irq_pend = '0; tx_fifo_empty = '1; rx_fifo_empty = '1; rx_pin = '1;
    ir_mode = '0; modem_in = '0; thr_wr = '0; status_rd = 0;
    divisor = {NCH{16'd5}};
  endtask

  task automatic go_sleep(input string req);
    sleep_en = 1; step(ENTRY + 4);
    chk(req, asleep, 1, "asleep after idle window");
  endtask

  initial begin
    rst = 1; sleep_en = 0; set_idle();
    step(3);
    chk("R1", clk_en, 1, "clk_en in reset");
    chk("R1", asleep, 0, "asleep in reset");
    rst = 0;
    chk("R1", wake_irq, 0, "wake_irq after reset");
    cmp_on = 1;

    // R2: exact window length
    cur_req = "R2";
    sleep_en = 1;
    step(ENTRY - 1); chk("R2", asleep, 0, "after 15 idle edges");
    step(1);         chk("R2", asleep, 1, "after 16 idle edges");
    chk("R10", clk_en, 0, "clk_en low while asleep");

    // R7/R8: THR write wakes and sets flag; R9 re-entry
    cur_req = "R7";
    thr_wr[2] = 1; step(1); thr_wr = '0;
    chk("R7", asleep, 0, "THR write wakes");
    chk("R8", wake_irq, 1, "wake flag set");
    cur_req = "R9";
    step(ENTRY - 1); chk("R9", asleep, 0, "not yet back asleep");
    step(1);         chk("R9", asleep, 1, "back asleep automatically");
    chk("R8", wake_irq, 1, "flag held without status read");
    cur_req = "R8";
    status_rd = 1; step(1); status_rd = 0;
    chk("R8", wake_irq, 0, "status read clears flag");

    // R7/R4: RX activity through synchronizer
    cur_req = "R7";
    rx_pin[1] = 0;
    step(2); chk("R4", asleep, 1, "RX edge still in synchronizer");
    step(1); chk("R7", asleep, 0, "RX activity wakes");
    rx_pin[1] = 1; step(1);
    go_sleep("R9");

    // modem activity
    modem_in[3*MW] = 1;
    step(3); chk("R7", asleep, 0, "modem activity wakes");
    modem_in = '0; step(1);
    go_sleep("R9");

    // interrupt while asleep
    irq_pend[0] = 1; step(1);
    chk("R7", asleep, 0, "interrupt wakes");
    irq_pend = '0;
    go_sleep("R9");

    // sleep_en cleared
    sleep_en = 0; step(1);
    chk("R7", asleep, 0, "clearing sleep_en wakes");
    cur_req = "R2";
    step(ENTRY + 8); chk("R2", asleep, 0, "no sleep with sleep_en low");
    status_rd = 1; step(1); status_rd = 0;

    // R3: single-channel blockers
    cur_req = "R3";
    sleep_en = 1;
    irq_pend[0] = 1; step(ENTRY + 8); chk("R3", asleep, 0, "pending irq blocks");
    irq_pend = '0; rx_fifo_empty[3] = 0; step(ENTRY + 8); chk("R3", asleep, 0, "RX FIFO data blocks");
    rx_fifo_empty = '1; tx_fifo_empty[1] = 0; step(ENTRY + 8); chk("R3", asleep, 0, "TX FIFO data blocks");
    tx_fifo_empty = '1;

    // R5: zero divisor
    cur_req = "R5";
    divisor[2*DW +: DW] = '0; step(ENTRY + 8); chk("R5", asleep, 0, "zero divisor blocks");
    divisor[2*DW +: DW] = 16'd7;

    // R4: infrared idle level, modem bit
    cur_req = "R4";
    ir_mode[0] = 1; step(ENTRY + 8); chk("R4", asleep, 0, "IR channel with RX high blocks");
    rx_pin[0] = 0; step(ENTRY + 4); chk("R4", asleep, 1, "IR channel with RX low sleeps");
    ir_mode[0] = 0; rx_pin[0] = 1; step(4);
    status_rd = 1; step(1); status_rd = 0;
    modem_in[1*MW + 3] = 1; step(ENTRY + 8); chk("R4", asleep, 0, "modem bit 3 blocks");
    modem_in = '0; step(2);

    // R6: one-cycle glitch restarts the count
    cur_req = "R6";
    sleep_en = 0; step(2); sleep_en = 1; step(10);
    irq_pend[1] = 1; step(1); irq_pend = '0;
    step(ENTRY - 1); chk("R6", asleep, 0, "count restarted after glitch");
    step(1);         chk("R6", asleep, 1, "sleeps 16 edges after glitch");

    // R8: wake and status read on the same edge
    cur_req = "R8";
    status_rd = 1; thr_wr[0] = 1; step(1); thr_wr = '0; status_rd = 0;
    chk("R8", wake_irq, 1, "set wins over status read");
    status_rd = 1; step(1); status_rd = 0;
    chk("R8", wake_irq, 0, "later status read clears");
    step(4);

    cmp_on = 0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule